// File: doc/BRIEF.md
# Load Queue with Memory-Ordering Violation Search

This block keeps the in-flight loads of an out-of-order core in program order, in a circular buffer with one more slot than its usable depth. Each dispatched load gets the slot at the tail and stores its sequence number and a tag that records the store queue's position at dispatch. Once the load computes its effective address, the address is written into the slot and marked valid.

When a load or a store executes, the core asks the queue whether some younger load has already obtained an address in the same 256-byte region. The queue walks the younger entries one per clock. It reports whether the walk recorded a new violator and holds the oldest violator found so far in a register, which the core reads and clears. Loads leave in bulk: from the head when they commit, and from the tail when the core squashes everything younger than a given sequence number. A saturating counter tracks how many violators have been recorded.

Dispatch and the violation query are valid/ready transfers. A transfer happens on a rising clock edge when both valid and ready are high. Valid may rise at any time and must hold its payload until the transfer. `disp_ready` is low while the queue is full or a squash is being applied. `chk_ready` is low while a walk is running or a squash is being applied. Neither ready depends on its own valid. All other pins are plain control and status.

Top module: `ldq_order_top`

## Requirements
- R1: After reset the queue is empty (`lq_empty`=1, `free_cnt`=DEPTH), `disp_ready`=1, `chk_ready`=1, `chk_busy`=0, `vio_present`=0 and `vio_count`=0.
- R2: A dispatch transfer writes the load into the tail slot. That slot index is shown on `disp_lq_idx` before the edge, and indices wrap modulo DEPTH+1. After DEPTH loads are held, `disp_ready` is 0 and `free_cnt` is 0, and a dispatch offered then changes nothing.
- R3: The stored store-queue tag is `disp_sq_tail`, or all ones when `disp_sq_empty` is 1. It is visible on `head_sq_tag` while the load is at the head.
- R4: A query with `chk_is_store`=0 walks from the slot after `chk_lq_idx`. A query with `chk_is_store`=1 walks from `chk_lq_idx` itself. The walk examines one slot per clock and stops at the tail. `chk_busy` is high during the walk, `chk_ready` is low during the walk, and `chk_done` pulses for one cycle at the end.
- R5: A walked slot matches only when its address is valid and its address shifted right by 8 equals the query address shifted right by 8. Slots without an address and slots in another region never match.
- R6: On the first match, the walk stops. The slot is recorded as the violator, with `chk_hit`=1, when no violator is held or its sequence number is smaller than the held one. Otherwise `chk_hit`=0 and the held violator is unchanged.
- R7: `vio_seq` and `vio_idx` give the held violator while `vio_present`=1. A `vio_take` pulse clears `vio_present` on the next cycle. A violator recorded on the same edge takes priority over the take.
- R8: A `cmt_en` pulse removes, in one cycle, every head entry whose sequence number is less than or equal to `cmt_seq`. The removal stops at the first entry that is younger.
- R9: An `sq_en` pulse removes, in one cycle, every tail entry whose sequence number is greater than `sq_seq`. It clears the violator when `sq_seq` is smaller than its sequence number, and it aborts any walk (`chk_done` with `chk_hit`=0). In that cycle, commit, dispatch and query acceptance are ignored.
- R10: `vio_count` rises by one for each recorded violator and saturates at 2^CNT_W-1 (7 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Queue can accept a dispatch |
| disp_seq | input | SEQ_W | Sequence number of dispatched load |
| disp_sq_tail | input | TAG_W | Store queue tail at dispatch |
| disp_sq_empty | input | 1 | Store queue holds no stores |
| disp_lq_idx | output | IW | Slot the dispatched load receives |
| addr_we | input | 1 | Write an effective address |
| addr_idx | input | IW | Slot receiving the address |
| addr_val | input | ADDR_W | Effective address |
| chk_valid | input | 1 | Violation query request |
| chk_ready | output | 1 | Query can be accepted |
| chk_is_store | input | 1 | Query comes from a store |
| chk_lq_idx | input | IW | Load-queue index of the executing instruction |
| chk_addr | input | ADDR_W | Address of the executing instruction |
| chk_busy | output | 1 | Walk in progress |
| chk_done | output | 1 | One-cycle pulse at walk end |
| chk_hit | output | 1 | Walk recorded a new violator (valid with chk_done) |
| vio_take | input | 1 | Read and clear the violator |
| vio_present | output | 1 | A violator is held |
| vio_seq | output | SEQ_W | Violator sequence number |
| vio_idx | output | IW | Violator slot |
| cmt_en | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Youngest committed sequence number |
| sq_en | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Sequence number kept by the squash |
| free_cnt | output | IW | Free usable slots |
| head_seq | output | SEQ_W | Sequence number at head |
| head_sq_tag | output | TAG_W | Store-queue tag at head |
| lq_empty | output | 1 | Queue holds no loads |
| vio_count | output | CNT_W | Saturating count of recorded violators |

## Verification
Queries are tried against a first match with no violator held, a first match that is older than the held violator and one that is younger, slots in a different region, and a slot with no address yet. Together these separate the region compare, the valid-bit gate and the replace-or-stop rule. Store queries and load queries on the same index show whether the start slot is included. Counting busy cycles on a walk with no match checks the one-slot-per-clock pace up to the tail. Squashes with a keep number just above and just below the violator's sequence number show whether the violator is cleared, and a fill past capacity followed by a wrapping refill exercises the sentinel full test and the modulo indexing.

// File: rtl/lq_pkg.sv
package lq_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_WALK = 1'b1
  } scan_state_e;

  localparam int unsigned REGION_SHIFT = 8;
endpackage

// File: rtl/lq_ring.sv
module lq_ring #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4,
  parameter int IW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_fire,
  input  logic [SEQ_W-1:0]  disp_seq,
  input  logic [TAG_W-1:0]  disp_tag,
  input  logic              addr_we,
  input  logic [IW-1:0]     addr_idx,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              cmt_en,
  input  logic [SEQ_W-1:0]  cmt_seq,
  input  logic              sq_en,
  input  logic [SEQ_W-1:0]  sq_seq,
  input  logic [IW-1:0]     rd_idx,
  output logic [SEQ_W-1:0]  rd_seq,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_aval,
  output logic [IW-1:0]     head_idx,
  output logic [IW-1:0]     tail_idx,
  output logic [IW-1:0]     used,
  output logic              full,
  output logic [SEQ_W-1:0]  head_seq,
  output logic [TAG_W-1:0]  head_tag
);
  localparam int SIZE = DEPTH + 1;

  logic [SEQ_W-1:0]  seq_mem  [SIZE];
  logic [ADDR_W-1:0] addr_mem [SIZE];
  logic              aval_mem [SIZE];
  logic [TAG_W-1:0]  tag_mem  [SIZE];

  logic [IW-1:0] head_q, tail_q, used_q;
  logic [IW-1:0] n_pop, n_kill;

  function automatic logic [IW-1:0] step_fwd(input logic [IW-1:0] p, input logic [IW-1:0] n);
    logic [IW:0] s;
    s = {1'b0, p} + {1'b0, n};
    if (s >= (IW+1)'(SIZE)) s = s - (IW+1)'(SIZE);
    return s[IW-1:0];
  endfunction

  function automatic logic [IW-1:0] step_back(input logic [IW-1:0] p, input logic [IW-1:0] n);
    logic [IW:0] s;
    s = {1'b0, p} + (IW+1)'(SIZE) - {1'b0, n};
    if (s >= (IW+1)'(SIZE)) s = s - (IW+1)'(SIZE);
    return s[IW-1:0];
  endfunction

  // Count of contiguous committed entries from the head.
  always_comb begin
    logic          run;
    logic [IW-1:0] slot;
    n_pop = '0;
    run   = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      slot = step_fwd(head_q, IW'(k));
      if (run && (IW'(k) < used_q) && (seq_mem[slot] <= cmt_seq)) n_pop = n_pop + IW'(1);
      else run = 1'b0;
    end
  end

  // Count of contiguous squashed entries back from the tail.
  always_comb begin
    logic          run;
    logic [IW-1:0] slot;
    n_kill = '0;
    run    = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      slot = step_back(tail_q, IW'(k + 1));
      if (run && (IW'(k) < used_q) && (seq_mem[slot] > sq_seq)) n_kill = n_kill + IW'(1);
      else run = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      used_q <= '0;
    end else if (sq_en) begin
      tail_q <= step_back(tail_q, n_kill);
      used_q <= used_q - n_kill;
    end else begin
      if (cmt_en) head_q <= step_fwd(head_q, n_pop);
      if (disp_fire) tail_q <= step_fwd(tail_q, IW'(1));
      used_q <= used_q - (cmt_en ? n_pop : '0) + (disp_fire ? IW'(1) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SIZE; i++) begin
        seq_mem[i]  <= '0;
        addr_mem[i] <= '0;
        aval_mem[i] <= 1'b0;
        tag_mem[i]  <= '0;
      end
    end else begin
      if (disp_fire) begin
        seq_mem[tail_q]  <= disp_seq;
        tag_mem[tail_q]  <= disp_tag;
        aval_mem[tail_q] <= 1'b0;
      end
      if (addr_we) begin
        addr_mem[addr_idx] <= addr_val;
        aval_mem[addr_idx] <= 1'b1;
      end
    end
  end

  assign rd_seq   = seq_mem[rd_idx];
  assign rd_addr  = addr_mem[rd_idx];
  assign rd_aval  = aval_mem[rd_idx];
  assign head_idx = head_q;
  assign tail_idx = tail_q;
  assign used     = used_q;
  assign full     = (step_fwd(tail_q, IW'(1)) == head_q);
  assign head_seq = seq_mem[head_q];
  assign head_tag = tag_mem[head_q];
endmodule

// File: rtl/lq_scan.sv
module lq_scan #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int IW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              from_store,
  input  logic [IW-1:0]     start_idx,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              abort,
  input  logic [IW-1:0]     tail_idx,
  output logic [IW-1:0]     rd_idx,
  input  logic [SEQ_W-1:0]  rd_seq,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_aval,
  input  logic              held_valid,
  input  logic [SEQ_W-1:0]  held_seq,
  output logic              busy,
  output logic              done,
  output logic              hit,
  output logic              rec_fire,
  output logic [IW-1:0]     rec_idx,
  output logic [SEQ_W-1:0]  rec_seq
);
  import lq_pkg::*;
  localparam int SIZE = DEPTH + 1;

  scan_state_e       state_q;
  logic [IW-1:0]     ptr_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q, hit_q;
  logic              at_tail, match, older;

  function automatic logic [IW-1:0] next_slot(input logic [IW-1:0] p);
    return (p == IW'(SIZE - 1)) ? '0 : p + IW'(1);
  endfunction

  assign at_tail  = (ptr_q == tail_idx);
  assign match    = rd_aval && ((rd_addr >> REGION_SHIFT) == (addr_q >> REGION_SHIFT));
  assign older    = !held_valid || (rd_seq < held_seq);
  assign rec_fire = (state_q == SCAN_WALK) && !abort && !at_tail && match && older;
  assign rec_idx  = ptr_q;
  assign rec_seq  = rd_seq;
  assign rd_idx   = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      ptr_q   <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == SCAN_WALK && abort) begin
        state_q <= SCAN_IDLE;
        done_q  <= 1'b1;
        hit_q   <= 1'b0;
      end else if (state_q == SCAN_IDLE && start) begin
        state_q <= SCAN_WALK;
        ptr_q   <= from_store ? start_idx : next_slot(start_idx);
        addr_q  <= start_addr;
        hit_q   <= 1'b0;
      end else if (state_q == SCAN_WALK) begin
        if (at_tail || match) begin
          state_q <= SCAN_IDLE;
          done_q  <= 1'b1;
          hit_q   <= rec_fire;
        end else begin
          ptr_q <= next_slot(ptr_q);
        end
      end
    end
  end

  assign busy = (state_q == SCAN_WALK);
  assign done = done_q;
  assign hit  = hit_q;
endmodule

// File: rtl/lq_satcnt.sv
module lq_satcnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] value
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (bump && (cnt_q != '1)) cnt_q <= cnt_q + W'(1);
  end

  assign value = cnt_q;
endmodule

// File: rtl/ldq_order_top.sv
module ldq_order_top #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4,
  parameter int CNT_W  = 3,
  parameter int IW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [SEQ_W-1:0]  disp_seq,
  input  logic [TAG_W-1:0]  disp_sq_tail,
  input  logic              disp_sq_empty,
  output logic [IW-1:0]     disp_lq_idx,
  input  logic              addr_we,
  input  logic [IW-1:0]     addr_idx,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              chk_valid,
  output logic              chk_ready,
  input  logic              chk_is_store,
  input  logic [IW-1:0]     chk_lq_idx,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_busy,
  output logic              chk_done,
  output logic              chk_hit,
  input  logic              vio_take,
  output logic              vio_present,
  output logic [SEQ_W-1:0]  vio_seq,
  output logic [IW-1:0]     vio_idx,
  input  logic              cmt_en,
  input  logic [SEQ_W-1:0]  cmt_seq,
  input  logic              sq_en,
  input  logic [SEQ_W-1:0]  sq_seq,
  output logic [IW-1:0]     free_cnt,
  output logic [SEQ_W-1:0]  head_seq,
  output logic [TAG_W-1:0]  head_sq_tag,
  output logic              lq_empty,
  output logic [CNT_W-1:0]  vio_count
);
  logic              disp_fire, chk_fire, full;
  logic [IW-1:0]     head_idx, tail_idx, used, rd_idx, rec_idx;
  logic [SEQ_W-1:0]  rd_seq, rec_seq;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_aval, rec_fire;
  logic              held_q;
  logic [SEQ_W-1:0]  held_seq_q;
  logic [IW-1:0]     held_idx_q;

  assign disp_ready = !full && !sq_en;
  assign disp_fire  = disp_valid && disp_ready;
  assign chk_ready  = !chk_busy && !sq_en;
  assign chk_fire   = chk_valid && chk_ready;

  lq_ring #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .IW(IW)) ring_i (
    .clk(clk), .rst_n(rst_n),
    .disp_fire(disp_fire), .disp_seq(disp_seq),
    .disp_tag(disp_sq_empty ? {TAG_W{1'b1}} : disp_sq_tail),
    .addr_we(addr_we), .addr_idx(addr_idx), .addr_val(addr_val),
    .cmt_en(cmt_en), .cmt_seq(cmt_seq), .sq_en(sq_en), .sq_seq(sq_seq),
    .rd_idx(rd_idx), .rd_seq(rd_seq), .rd_addr(rd_addr), .rd_aval(rd_aval),
    .head_idx(head_idx), .tail_idx(tail_idx), .used(used), .full(full),
    .head_seq(head_seq), .head_tag(head_sq_tag)
  );

  lq_scan #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .IW(IW)) scan_i (
    .clk(clk), .rst_n(rst_n),
    .start(chk_fire), .from_store(chk_is_store), .start_idx(chk_lq_idx), .start_addr(chk_addr),
    .abort(sq_en), .tail_idx(tail_idx),
    .rd_idx(rd_idx), .rd_seq(rd_seq), .rd_addr(rd_addr), .rd_aval(rd_aval),
    .held_valid(held_q), .held_seq(held_seq_q),
    .busy(chk_busy), .done(chk_done), .hit(chk_hit),
    .rec_fire(rec_fire), .rec_idx(rec_idx), .rec_seq(rec_seq)
  );

  lq_satcnt #(.W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .bump(rec_fire), .value(vio_count)
  );

  // Oldest-violator register: record beats squash-clear beats take.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q     <= 1'b0;
      held_seq_q <= '0;
      held_idx_q <= '0;
    end else if (rec_fire) begin
      held_q     <= 1'b1;
      held_seq_q <= rec_seq;
      held_idx_q <= rec_idx;
    end else if (sq_en && held_q && (sq_seq < held_seq_q)) begin
      held_q <= 1'b0;
    end else if (vio_take) begin
      held_q <= 1'b0;
    end
  end

  assign vio_present = held_q;
  assign vio_seq     = held_seq_q;
  assign vio_idx     = held_idx_q;
  assign disp_lq_idx = tail_idx;
  assign free_cnt    = IW'(DEPTH) - used;
  assign lq_empty    = (head_idx == tail_idx);
endmodule

// File: rtl/ldq_order_chk.sv
module ldq_order_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 3,
  parameter int IW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic [IW-1:0]    free_cnt,
  input logic             chk_ready,
  input logic             chk_busy,
  input logic             chk_done,
  input logic             chk_hit,
  input logic             vio_take,
  input logic             vio_present,
  input logic [CNT_W-1:0] vio_count,
  input logic             cmt_en,
  input logic             sq_en
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= IW'(DEPTH)); // R2
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == '0) |-> !disp_ready); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    chk_busy |-> !chk_ready); // R4
  AST_DONE_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |-> !chk_busy); // R4
  AST_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_done && chk_hit) |-> vio_present); // R6
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (vio_take && !chk_busy) |=> !vio_present); // R7
  AST_COMMIT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_en && !sq_en && !(disp_valid && disp_ready)) |=> (free_cnt >= $past(free_cnt))); // R8
  AST_SQUASH_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    sq_en |=> !chk_busy); // R9
  AST_SQUASH_NO_DISP: assert property (@(posedge clk) disable iff (!rst_n)
    sq_en |-> !disp_ready); // R9
  AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (vio_count >= $past(vio_count))); // R10
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (vio_count == '1) |=> (vio_count == '1)); // R10
endmodule

bind ldq_order_top ldq_order_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IW(IW)) chk_i (.*);

// File: tb/ldq_order_top_tb_top.sv
module ldq_order_top_tb_top;
  localparam int DEPTH = 8, SEQ_W = 16, ADDR_W = 32, TAG_W = 4, CNT_W = 3, IW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, disp_valid, disp_ready, disp_sq_empty, addr_we;
  logic chk_valid, chk_ready, chk_is_store, chk_busy, chk_done, chk_hit;
  logic vio_take, vio_present, cmt_en, sq_en, lq_empty;
  logic [SEQ_W-1:0] disp_seq, vio_seq, cmt_seq, sq_seq, head_seq;
  logic [TAG_W-1:0] disp_sq_tail, head_sq_tag;
  logic [IW-1:0] disp_lq_idx, addr_idx, chk_lq_idx, vio_idx, free_cnt;
  logic [ADDR_W-1:0] addr_val, chk_addr;
  logic [CNT_W-1:0] vio_count;

  ldq_order_top #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) dut_i (.*);

  int checks = 0, errors = 0;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  typedef struct { bit hit; int seq; string req; } exp_t;
  exp_t sb[$];

  // Monitor: pops the expected walk result at each completion.
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && chk_done) begin
      if (sb.size() == 0) check("R4", "unexpected chk_done", 1, 0);
      else begin
        e = sb.pop_front();
        check(e.req, "walk hit", chk_hit, e.hit);
        if (e.hit) check(e.req, "violator seq", vio_seq, e.seq);
      end
    end
  end

  task automatic dispatch(int seq, int tag, bit empty, output int idx, output bit took);
    disp_valid = 1; disp_seq = SEQ_W'(seq); disp_sq_tail = TAG_W'(tag); disp_sq_empty = empty;
    #1; took = disp_ready; idx = int'(disp_lq_idx);
    @(negedge clk); disp_valid = 0;
  endtask

  task automatic set_addr(int idx, int a);
    addr_we = 1; addr_idx = IW'(idx); addr_val = ADDR_W'(a);
    @(negedge clk); addr_we = 0;
  endtask

  task automatic run_check(bit st, int idx, int a, bit eh, int es, string req, output int busy_n);
    sb.push_back('{eh, es, req});
    chk_valid = 1; chk_is_store = st; chk_lq_idx = IW'(idx); chk_addr = ADDR_W'(a);
    @(negedge clk); chk_valid = 0; busy_n = 0;
    check("R4", "ready low while walking", chk_ready, 0);
    while (!chk_done) begin
      if (chk_busy) busy_n++;
      @(negedge clk);
    end
  endtask

  task automatic commit(int s);
    cmt_en = 1; cmt_seq = SEQ_W'(s); @(negedge clk); cmt_en = 0;
  endtask

  task automatic squash(int s);
    sq_en = 1; sq_seq = SEQ_W'(s); @(negedge clk); sq_en = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    int idx, bn, ia, ib;
    bit took;
    rst_n = 0; disp_valid = 0; disp_seq = 0; disp_sq_tail = 0; disp_sq_empty = 0;
    addr_we = 0; addr_idx = 0; addr_val = 0; chk_valid = 0; chk_is_store = 0;
    chk_lq_idx = 0; chk_addr = 0; vio_take = 0; cmt_en = 0; cmt_seq = 0; sq_en = 0; sq_seq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "lq_empty", lq_empty, 1);
    check("R1", "free_cnt", free_cnt, DEPTH);
    check("R1", "disp_ready", disp_ready, 1);
    check("R1", "chk_ready/busy", {chk_ready, chk_busy}, 2'b10);
    check("R1", "vio_present", vio_present, 0);
    check("R1", "vio_count", vio_count, 0);

    dispatch(10, 3, 1, idx, took); check("R2", "first index", idx, 0);
    check("R3", "empty store queue tag all ones", head_sq_tag, 15);
    dispatch(11, 5, 0, idx, took); check("R2", "second index", idx, 1);
    dispatch(12, 6, 0, idx, took); check("R2", "third index", idx, 2);
    set_addr(0, 'h1200); set_addr(1, 'h1234); set_addr(2, 'h1299);

    run_check(0, 0, 'h1200, 1, 11, "R6", bn); // first match, none held
    check("R10", "count after one record", vio_count, 1);
    run_check(0, 0, 'h1200, 0, 0, "R6", bn);  // same seq as held: stop, no hit
    check("R6", "held seq unchanged", vio_seq, 11);

    vio_take = 1; #1; check("R7", "taken seq", vio_seq, 11);
    @(negedge clk); vio_take = 0;
    check("R7", "cleared after take", vio_present, 0);

    run_check(1, 2, 'h1250, 1, 12, "R4", bn); // store includes its own slot
    run_check(0, 2, 'h1250, 0, 0, "R4", bn);  // load skips own slot, reaches tail
    check("R4", "busy cycles empty walk", bn, 1);
    run_check(0, 0, 'h1200, 1, 11, "R6", bn); // older match replaces held 12
    check("R10", "count after three records", vio_count, 3);

    dispatch(13, 7, 0, idx, took); check("R2", "fourth index", idx, 3);
    run_check(1, 0, 'h5500, 0, 0, "R5", bn);  // other region everywhere
    run_check(0, 2, 'h1200, 0, 0, "R5", bn);  // only slot 3, no address yet
    run_check(0, 0, 'h9900, 0, 0, "R4", bn);
    check("R4", "one slot per clock", bn, 4);

    commit(5);  check("R8", "commit none free", free_cnt, 4);
    squash(12); check("R9", "squash one free", free_cnt, 5);
    check("R9", "violator kept (12 not < 11)", vio_present, 1);
    squash(10); check("R9", "squash younger free", free_cnt, 7);
    check("R9", "violator cleared", vio_present, 0);
    commit(10); check("R8", "commit head", lq_empty, 1);

    for (int i = 0; i < DEPTH; i++) dispatch(200 + i, 9, 0, idx, took);
    check("R2", "full ready low", disp_ready, 0);
    check("R2", "full free zero", free_cnt, 0);
    dispatch(300, 1, 0, idx, took);
    check("R2", "offer when full refused", took, 0);
    check("R2", "head unchanged", head_seq, 200);
    check("R3", "stored store tag", head_sq_tag, 9);
    commit(203); check("R8", "partial commit free", free_cnt, 4);
    check("R8", "new head", head_seq, 204);
    dispatch(208, 2, 0, idx, took); check("R2", "wrapped index", idx, 0);
    commit(1000); check("R8", "commit all", lq_empty, 1);

    for (int i = 0; i < 7; i++) begin
      squash(0);
      dispatch(100 + 2 * i, i, 0, ia, took);
      dispatch(101 + 2 * i, i, 0, ib, took);
      set_addr(ia, 'h4400); set_addr(ib, 'h44F0);
      run_check(0, ia, 'h4410, 1, 101 + 2 * i, "R10", bn);
      check("R10", "saturating count", vio_count, (4 + i > 7) ? 7 : 4 + i);
    end

    repeat (3) @(negedge clk);
    check("R4", "scoreboard drained", sb.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule